// File: doc/BRIEF.md
# Intercept Substitution Data Controller

This block sits between a serial sample port and a codec. For each of five stereo channel pairs it decides, once per frame, whether sample data received over the port replaces the sample that the internal source would otherwise send to the codec. The five pairs are capture, playback, synthesizer playback, auxiliary port 1 playback and auxiliary port 0 playback. After reset the port only observes traffic, so every pair passes its original samples through.

A substitution for a pair is accepted at the end of a frame only when three things are true: the pair's intercept-enable bit is set, the block flagged a data request for the pair in the previous frame, and the pair's valid flag is set in this frame's control word. An accepted pair pulses a one-cycle strobe, and its left and right samples are both taken from the received slots until the next frame end. A rejected pair gets the original samples unchanged. Request flags come in per pair during a frame. They are registered at frame end and shown in a status word. When a pair's rate equals the frame rate, its request and valid inputs are simply tied high.

Top module: `icpt_subst_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it, `sub_strobe` is 0, `status_word` is 0, and every pair's `out_l`/`out_r` equals its `orig_l`/`orig_r` slice.
- R2: On the cycle after a `frame_end` pulse, `sub_strobe[k]` is 1 exactly when pair k was accepted, and for the rest of the frame `out_l`/`out_r` for pair k carry the data received in its slots. A pair is accepted when `icpt_en[k]` is set, status bit 7+k was set during the frame, and the control-word valid bit k was set. The strobe lasts one cycle.
- R3: If `icpt_en[k]` is 0 at frame end, pair k's valid flag and slot data are ignored: there is no strobe and the original samples are output.
- R4: If no request was flagged for pair k during the frame (status bit 7+k was 0), pair k's valid flag is ignored. A request presented on `req_in` during a frame qualifies only the following frame.
- R5: If valid bit k of the frame's control word is 0, pair k is not substituted and its original samples are output.
- R6: The control word is slot 0, with valid bit k for pair k at data bit k. Pair k (0 capture, 1 playback, 2 synthesizer, 3 auxiliary 1, 4 auxiliary 0) takes its right sample from slot 2+2k and its left sample from slot 3+2k.
- R7: `status_word` shows the request of pair k at bit 7+k, so the synthesizer request is at bit 9. All other bits are 0. The word changes only on the cycle after `frame_end`, when it takes the `req_in` value sampled at that frame end.
- R8: The choice between received and original samples is made for a whole pair at once, left and right together. It holds until the next frame end, while the original inputs stay live for pairs that were not substituted.
- R9: Valid flags are cleared at every frame end. A frame whose slot 0 was not written accepts no substitution, even when its data slots were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| slot_wr | input | 1 | A received slot word is present this cycle |
| slot_idx | input | 4 | Index of the received slot |
| slot_data | input | 16 | Received slot word |
| frame_end | input | 1 | One-cycle pulse closing a frame (never together with slot_wr) |
| icpt_en | input | 5 | Per-pair intercept enable from configuration |
| req_in | input | 5 | Per-pair data request raised during the current frame |
| orig_l | input | 80 | Original left samples, pair k at bits 16k+15:16k |
| orig_r | input | 80 | Original right samples, same packing |
| out_l | output | 80 | Left samples to the codec, same packing |
| out_r | output | 80 | Right samples to the codec, same packing |
| sub_strobe | output | 5 | One-cycle pulse per accepted pair after frame end |
| status_word | output | 16 | Registered request flags, pair k at bit 7+k |

## Verification
A wrong request register shows up in `status_word` on the cycle after the frame end that loaded it. It also shows up as a missing or extra strobe one frame later. A stale valid flag, or a slot decoded to the wrong pair, shows up one cycle after the frame end. It appears as a strobe that should not be there or as wrong data on the outputs, and it stays visible for the whole following frame, so every slot carries a distinct value. A wrong select bit makes an output stop following its moving original input at once, so the original samples change while substitutions are held.

// File: rtl/icpt_pkg.sv
// Shared definitions for the intercept substitution controller.
// Assumes slot numbering starts at 0 with the control word in slot 0.
package icpt_pkg;
    // Pair index order; the slot map and status bits depend on it.
    typedef enum logic [2:0] {
        PAIR_CAPTURE  = 3'd0,
        PAIR_PLAYBACK = 3'd1,
        PAIR_SYNTH    = 3'd2,
        PAIR_AUX1     = 3'd3,
        PAIR_AUX0     = 3'd4
    } pair_e;

    // Right-sample slot of a pair; the left sample follows it.
    function automatic int unsigned right_slot(input int unsigned first, input int unsigned pair);
        return first + 2 * pair;
    endfunction
endpackage

// File: rtl/icpt_slot_capture.sv
// Captures the control word valid flags and per-pair staging samples
// from received slots. Assumes frame_end never coincides with slot_wr.
module icpt_slot_capture #(
    parameter int unsigned NPAIR      = 5,
    parameter int unsigned DW         = 16,
    parameter int unsigned SLOT_W     = 4,
    parameter int unsigned CTRL_SLOT  = 0,
    parameter int unsigned FIRST_SLOT = 2,
    parameter int unsigned VLD_LSB    = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  slot_wr,
    input  logic [SLOT_W-1:0]     slot_idx,
    input  logic [DW-1:0]         slot_data,
    input  logic                  frame_end,
    output logic [NPAIR-1:0]      vld,
    output logic [NPAIR*DW-1:0]   stage_l,
    output logic [NPAIR*DW-1:0]   stage_r
);
    import icpt_pkg::*;
    localparam logic [SLOT_W-1:0] CTRL_IDX = SLOT_W'(CTRL_SLOT);

    // Valid flags: loaded from the control word, cleared at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vld <= '0;
        else if (frame_end)
            vld <= '0;
        else if (slot_wr && slot_idx == CTRL_IDX)
            vld <= slot_data[VLD_LSB +: NPAIR];
    end

    for (genvar k = 0; k < NPAIR; k++) begin : g_stage
        localparam logic [SLOT_W-1:0] R_IDX = SLOT_W'(right_slot(FIRST_SLOT, k));
        localparam logic [SLOT_W-1:0] L_IDX = SLOT_W'(right_slot(FIRST_SLOT, k) + 1);

        // Staging samples: latch the slot words belonging to pair k.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_r[k*DW +: DW] <= '0;
                stage_l[k*DW +: DW] <= '0;
            end else if (slot_wr) begin
                if (slot_idx == R_IDX) stage_r[k*DW +: DW] <= slot_data;
                if (slot_idx == L_IDX) stage_l[k*DW +: DW] <= slot_data;
            end
        end
    end
endmodule

// File: rtl/icpt_qualifier.sv
// Holds the previous frame's request flags and makes the per-pair
// accept decision at frame end. Assumes frame_end is a one-cycle pulse.
module icpt_qualifier #(
    parameter int unsigned NPAIR   = 5,
    parameter int unsigned STAT_W  = 16,
    parameter int unsigned REQ_LSB = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_end,
    input  logic [NPAIR-1:0]   icpt_en,
    input  logic [NPAIR-1:0]   req_in,
    input  logic [NPAIR-1:0]   vld,
    output logic [NPAIR-1:0]   accept,
    output logic [NPAIR-1:0]   use_sub,
    output logic [NPAIR-1:0]   sub_strobe,
    output logic [STAT_W-1:0]  status_word
);
    logic [NPAIR-1:0] req_q;

    // Decision: all three qualifiers must hold for a pair.
    always_comb accept = icpt_en & req_q & vld;

    // Frame-end update of requests, strobes and the frame's select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q      <= '0;
            use_sub    <= '0;
            sub_strobe <= '0;
        end else if (frame_end) begin
            req_q      <= req_in;
            use_sub    <= accept;
            sub_strobe <= accept;
        end else begin
            sub_strobe <= '0;
        end
    end

    // Status word assembly: request flags at their reported positions.
    always_comb begin
        status_word = '0;
        status_word[REQ_LSB +: NPAIR] = req_q;
    end
endmodule

// File: rtl/icpt_pair_mux.sv
// Holds accepted substitution samples per pair and selects them or the
// original samples. Assumes accept is only meaningful with frame_end.
module icpt_pair_mux #(
    parameter int unsigned NPAIR = 5,
    parameter int unsigned DW    = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_end,
    input  logic [NPAIR-1:0]     accept,
    input  logic [NPAIR-1:0]     use_sub,
    input  logic [NPAIR*DW-1:0]  stage_l,
    input  logic [NPAIR*DW-1:0]  stage_r,
    input  logic [NPAIR*DW-1:0]  orig_l,
    input  logic [NPAIR*DW-1:0]  orig_r,
    output logic [NPAIR*DW-1:0]  out_l,
    output logic [NPAIR*DW-1:0]  out_r
);
    logic [NPAIR*DW-1:0] hold_l, hold_r;

    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        // Hold registers: copy both staged samples of an accepted pair.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_l[k*DW +: DW] <= '0;
                hold_r[k*DW +: DW] <= '0;
            end else if (frame_end && accept[k]) begin
                hold_l[k*DW +: DW] <= stage_l[k*DW +: DW];
                hold_r[k*DW +: DW] <= stage_r[k*DW +: DW];
            end
        end

        // Output select: one bit steers left and right together.
        always_comb begin
            out_l[k*DW +: DW] = use_sub[k] ? hold_l[k*DW +: DW] : orig_l[k*DW +: DW];
            out_r[k*DW +: DW] = use_sub[k] ? hold_r[k*DW +: DW] : orig_r[k*DW +: DW];
        end
    end
endmodule

// File: rtl/icpt_subst_ctrl.sv
// Top of the intercept substitution controller: slot capture, frame-end
// qualification and per-pair output selection. Assumes slot and frame
// timing come from an external serial port block.
module icpt_subst_ctrl #(
    parameter int unsigned NPAIR      = 5,
    parameter int unsigned DW         = 16,
    parameter int unsigned SLOT_W     = 4,
    parameter int unsigned STAT_W     = 16,
    parameter int unsigned REQ_LSB    = 7,
    parameter int unsigned FIRST_SLOT = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 slot_wr,
    input  logic [SLOT_W-1:0]    slot_idx,
    input  logic [DW-1:0]        slot_data,
    input  logic                 frame_end,
    input  logic [NPAIR-1:0]     icpt_en,
    input  logic [NPAIR-1:0]     req_in,
    input  logic [NPAIR*DW-1:0]  orig_l,
    input  logic [NPAIR*DW-1:0]  orig_r,
    output logic [NPAIR*DW-1:0]  out_l,
    output logic [NPAIR*DW-1:0]  out_r,
    output logic [NPAIR-1:0]     sub_strobe,
    output logic [STAT_W-1:0]    status_word
);
    logic [NPAIR-1:0]    vld, accept, use_sub;
    logic [NPAIR*DW-1:0] stage_l, stage_r;

    icpt_slot_capture #(
        .NPAIR(NPAIR), .DW(DW), .SLOT_W(SLOT_W),
        .CTRL_SLOT(0), .FIRST_SLOT(FIRST_SLOT), .VLD_LSB(0)
    ) u_capture (
        .clk(clk), .rst_n(rst_n), .slot_wr(slot_wr), .slot_idx(slot_idx),
        .slot_data(slot_data), .frame_end(frame_end),
        .vld(vld), .stage_l(stage_l), .stage_r(stage_r)
    );

    icpt_qualifier #(
        .NPAIR(NPAIR), .STAT_W(STAT_W), .REQ_LSB(REQ_LSB)
    ) u_qual (
        .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .icpt_en(icpt_en),
        .req_in(req_in), .vld(vld), .accept(accept), .use_sub(use_sub),
        .sub_strobe(sub_strobe), .status_word(status_word)
    );

    icpt_pair_mux #(
        .NPAIR(NPAIR), .DW(DW)
    ) u_mux (
        .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .accept(accept),
        .use_sub(use_sub), .stage_l(stage_l), .stage_r(stage_r),
        .orig_l(orig_l), .orig_r(orig_r), .out_l(out_l), .out_r(out_r)
    );
endmodule

// File: rtl/icpt_checker.sv
// Port-level properties of the intercept substitution controller.
// Assumes it is bound to icpt_subst_ctrl with matching parameters.
module icpt_checker #(
    parameter int unsigned NPAIR   = 5,
    parameter int unsigned DW      = 16,
    parameter int unsigned STAT_W  = 16,
    parameter int unsigned REQ_LSB = 7
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 frame_end,
    input logic [NPAIR-1:0]     icpt_en,
    input logic [NPAIR*DW-1:0]  orig_l,
    input logic [NPAIR*DW-1:0]  orig_r,
    input logic [NPAIR*DW-1:0]  out_l,
    input logic [NPAIR*DW-1:0]  out_r,
    input logic [NPAIR-1:0]     sub_strobe,
    input logic [STAT_W-1:0]    status_word
);
    // R1: first cycle out of reset shows no strobe and no requests.
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (sub_strobe == '0 && status_word == '0));

    // R2: strobes appear only on the cycle after a frame end.
    p_strobe_after_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_strobe != '0) |-> $past(frame_end));

    // R3: no strobe for a pair whose intercept was disabled at frame end.
    p_strobe_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_strobe != '0) |-> ((sub_strobe & ~$past(icpt_en)) == '0));

    // R4: no strobe for a pair without a previously reported request.
    p_strobe_requested_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_strobe != '0) |-> ((sub_strobe & ~$past(status_word[REQ_LSB +: NPAIR])) == '0));

    // R7: status word only moves right after a frame end, unused bits zero.
    p_status_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_end) |-> $stable(status_word));
    p_status_unused_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(status_word) == $countones(status_word[REQ_LSB +: NPAIR]));

    // R8: without a frame end and with steady originals, outputs hold.
    p_hold_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(frame_end) && $stable(orig_l) && $stable(orig_r))
            |-> ($stable(out_l) && $stable(out_r)));
endmodule

bind icpt_subst_ctrl icpt_checker #(
    .NPAIR(NPAIR), .DW(DW), .STAT_W(STAT_W), .REQ_LSB(REQ_LSB)
) u_icpt_checker (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .icpt_en(icpt_en),
    .orig_l(orig_l), .orig_r(orig_r), .out_l(out_l), .out_r(out_r),
    .sub_strobe(sub_strobe), .status_word(status_word)
);

// File: tb/icpt_subst_ctrl_test.sv
`timescale 1ns/100ps
// Bench for icpt_subst_ctrl: a behavioural reference model is stepped on
// every rising edge and compared with the outputs on every falling edge.
module icpt_subst_ctrl_test;
    localparam int NP = 5;
    localparam int DW = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              slot_wr = 1'b0;
    logic [3:0]        slot_idx = '0;
    logic [DW-1:0]     slot_data = '0;
    logic              frame_end = 1'b0;
    logic [NP-1:0]     icpt_en = '0;
    logic [NP-1:0]     req_in = '0;
    logic [NP*DW-1:0]  orig_l = '0, orig_r = '0;
    logic [NP*DW-1:0]  out_l, out_r;
    logic [NP-1:0]     sub_strobe;
    logic [15:0]       status_word;

    icpt_subst_ctrl uut (
        .clk(clk), .rst_n(rst_n), .slot_wr(slot_wr), .slot_idx(slot_idx),
        .slot_data(slot_data), .frame_end(frame_end), .icpt_en(icpt_en),
        .req_in(req_in), .orig_l(orig_l), .orig_r(orig_r), .out_l(out_l),
        .out_r(out_r), .sub_strobe(sub_strobe), .status_word(status_word)
    );

    always #2.5 clk = ~clk;

    int    vectors = 0, miscompares = 0;
    string cur_tag = "R1";
    bit    done = 0;

    // Reference model state, one entry per pair.
    int m_stage_l[NP], m_stage_r[NP], m_hold_l[NP], m_hold_r[NP];
    bit m_vld[NP], m_req[NP], m_use[NP], m_strobe[NP];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NP; k++) begin
                m_stage_l[k] = 0; m_stage_r[k] = 0; m_hold_l[k] = 0; m_hold_r[k] = 0;
                m_vld[k] = 0; m_req[k] = 0; m_use[k] = 0; m_strobe[k] = 0;
            end
        end else if (frame_end) begin
            for (int k = 0; k < NP; k++) begin
                bit ok;
                ok = icpt_en[k] && m_req[k] && m_vld[k];
                m_strobe[k] = ok;
                m_use[k] = ok;
                if (ok) begin
                    m_hold_l[k] = m_stage_l[k];
                    m_hold_r[k] = m_stage_r[k];
                end
                m_req[k] = req_in[k];
                m_vld[k] = 0;
            end
        end else begin
            for (int k = 0; k < NP; k++) m_strobe[k] = 0;
            if (slot_wr) begin
                if (slot_idx == 0)
                    for (int k = 0; k < NP; k++) m_vld[k] = slot_data[k];
                for (int k = 0; k < NP; k++) begin
                    if (int'(slot_idx) == 2 + 2*k) m_stage_r[k] = int'(slot_data);
                    if (int'(slot_idx) == 3 + 2*k) m_stage_l[k] = int'(slot_data);
                end
            end
        end
    end

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            logic [15:0]   exp_stat;
            logic [NP-1:0] exp_strobe;
            vectors++;
            exp_stat = '0;
            for (int k = 0; k < NP; k++) begin
                exp_stat[7+k] = m_req[k];
                exp_strobe[k] = m_strobe[k];
            end
            if (sub_strobe !== exp_strobe) begin
                miscompares++;
                $display("FAIL %s sub_strobe actual %b expected %b", cur_tag, sub_strobe, exp_strobe);
            end
            if (status_word !== exp_stat) begin
                miscompares++;
                $display("FAIL %s status_word actual %h expected %h", cur_tag, status_word, exp_stat);
            end
            for (int k = 0; k < NP; k++) begin
                logic [DW-1:0] el, er;
                el = m_use[k] ? DW'(m_hold_l[k]) : orig_l[k*DW +: DW];
                er = m_use[k] ? DW'(m_hold_r[k]) : orig_r[k*DW +: DW];
                if (out_l[k*DW +: DW] !== el || out_r[k*DW +: DW] !== er) begin
                    miscompares++;
                    $display("FAIL %s pair %0d out L/R actual %h/%h expected %h/%h",
                             cur_tag, k, out_l[k*DW +: DW], out_r[k*DW +: DW], el, er);
                end
            end
        end
    end

    int frame_no = 0;

    task automatic tick();
        @(posedge clk); #1;
    endtask

    // Move original samples so pass-through is visible.
    task automatic bump_orig();
        for (int k = 0; k < NP; k++) begin
            orig_l[k*DW +: DW] = orig_l[k*DW +: DW] + 16'h0101 + DW'(k);
            orig_r[k*DW +: DW] = orig_r[k*DW +: DW] + 16'h0203 + DW'(k);
        end
    endtask

    // One frame: optional control word, all data slots, then frame end.
    task automatic run_frame(input bit send_ctrl, input logic [NP-1:0] vbits,
                             input logic [NP-1:0] en, input logic [NP-1:0] req);
        frame_no++;
        icpt_en = en;
        req_in  = req;
        if (send_ctrl) begin
            tick();
            slot_wr = 1'b1; slot_idx = 4'd0; slot_data = {11'd0, vbits};
        end
        for (int s = 2; s < 12; s++) begin
            tick();
            slot_wr = 1'b1; slot_idx = 4'(s);
            slot_data = {4'(frame_no), 4'(s), 8'hA5 ^ 8'(frame_no)};
            if (s == 6) bump_orig();
        end
        tick();
        slot_wr = 1'b0;
        tick();
        frame_end = 1'b1;
        tick();
        frame_end = 1'b0;
        for (int i = 0; i < 3; i++) begin
            tick();
            bump_orig();
        end
    endtask

    initial begin
        for (int k = 0; k < NP; k++) begin
            orig_l[k*DW +: DW] = DW'(16'h1000 * k + 1);
            orig_r[k*DW +: DW] = DW'(16'h1000 * k + 2);
        end
        cur_tag = "R1";                                  // reset state
        repeat (4) tick();
        bump_orig();
        tick();
        rst_n = 1'b1;
        repeat (3) tick();
        cur_tag = "R4";                                  // no prior request
        run_frame(1, 5'b11111, 5'b11111, 5'b11111);
        cur_tag = "R2";                                  // all pairs accepted
        run_frame(1, 5'b11111, 5'b11111, 5'b11111);
        cur_tag = "R6";                                  // slot map, partial set
        run_frame(1, 5'b10101, 5'b11111, 5'b11111);
        cur_tag = "R3";                                  // intercept disabled
        run_frame(1, 5'b11111, 5'b01010, 5'b00110);
        cur_tag = "R7";                                  // requests from last frame
        run_frame(1, 5'b11111, 5'b11111, 5'b11001);
        cur_tag = "R4";                                  // only pairs 0,3,4 requested
        run_frame(1, 5'b11111, 5'b11111, 5'b11111);
        cur_tag = "R5";                                  // valid clear on some
        run_frame(1, 5'b01001, 5'b11111, 5'b11111);
        cur_tag = "R9";                                  // no control word
        run_frame(0, 5'b11111, 5'b11111, 5'b11111);
        cur_tag = "R8";                                  // hold through idle
        run_frame(1, 5'b00100, 5'b11111, 5'b00100);
        for (int i = 0; i < 20; i++) begin
            tick();
            bump_orig();
        end
        cur_tag = "R1";                                  // reset mid-stream
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        repeat (3) tick();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            miscompares++;
            $display("FAIL watchdog expired, actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule